// File: doc/BRIEF.md
# Paged Byte-Load Programming Controller

This block is the write side of a 32-bit wide non-volatile array. A host loads single bytes into a page buffer with a one-cycle write strobe. The first accepted byte opens a load session. Each later byte must arrive within a fixed window, counted from the previous accepted byte. When no byte has been accepted for a longer commit interval, the controller starts an internal programming cycle on its own. That cycle merges the buffered bytes into the array, one word per cycle, and then runs out a fixed programming time.

While a session or a programming cycle is in progress, the controller drives an open-drain ready/busy pin low. At all other times that pin floats. The pin is modelled as an output enable and a data bit that is always low. A read made during programming does not reach the array. It returns a status word whose lane top bits carry the inverse of bit 7 of the last loaded byte, so software can poll until the true data appears. An active-low inhibit input is level sensitive. While it is low, reads return nothing, strobes are dropped and programming holds in place. All timing is set in clock cycles, derived from a clock-frequency parameter and microsecond figures.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `rdy_oe` is 0, `rdy_o` is 0 and every array word reads as 0.
- R2: A strobe accepted while idle raises `rdy_oe` from the next cycle on, and `rdy_oe` stays high until programming ends. `rdy_o` is 0 at all times.
- R3: Byte loads of one session go into a page buffer indexed by `wr_addr[6:0]`. A repeated offset keeps the last value. A session holds anywhere from 1 to 128 bytes.
- R4: A load is accepted if it arrives at most LOAD_WIN cycles (300 by default) after the previous accepted load, counted edge to edge. A load arriving later is ignored and does not restart any timer.
- R5: Programming starts COMMIT cycles (1000) after the last accepted load. It lasts PROG_CYC (500) cycles during which `inhibit_n` is high. `rdy_oe` falls right after the last of those cycles.
- R6: After programming, each loaded byte is stored in the array. Byte address b maps to word b[8:2], lane b[1:0], and lane k is `rdata[8k+7:8k]`. Unloaded bytes of the page, and all other pages, keep their old contents.
- R7: A read whose request cycle falls in programming returns `rvalid`=1 and a status word. Bits 7, 15, 23 and 31 hold the inverse of bit 7 of the last accepted byte; all other bits are 0.
- R8: Outside programming, a read returns the array word one cycle after the request, with `rvalid`=1. During a load session this is still the old array data.
- R9: While `inhibit_n` is low, a read returns `rvalid`=0 and `rdata`=0, strobes are ignored, and programming cycles do not count.
- R10: Strobes during programming are ignored, and so are strobes addressed to a page other than the one that opened the session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inhibit_n | input | 1 | Level-sensitive block of reads and programming, active low |
| wr_stb | input | 1 | One-cycle byte-load strobe |
| wr_addr | input | 9 | Byte address of the load |
| wr_data | input | 8 | Byte to load |
| rd_en | input | 1 | Read request |
| rd_addr | input | 7 | Word address of the read |
| rdata | output | 32 | Read data or polling status word |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |
| rdy_oe | output | 1 | Drive enable of the ready/busy pin |
| rdy_o | output | 1 | Data bit of the ready/busy pin, always low |

## Verification
The bench places loads exactly at the window limit and one cycle past it. A design with an off-by-one in the window would either drop the first load or store the second. It holds `inhibit_n` low in the middle of programming and expects the busy time to stretch by exactly that many cycles, which exposes a counter that keeps running while inhibited. It also sends strobes to a foreign page and into the programming phase, then reads the whole page back. A controller that lets such strobes through would corrupt a neighbour page or retrigger a session. The polling word is checked against the last accepted byte, not the last strobed one.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;

   typedef enum logic [1:0] {
      PW_IDLE = 2'd0,
      PW_LOAD = 2'd1,
      PW_PROG = 2'd2
   } pw_state_e;

   // microseconds to clock cycles for a clock given in kHz
   function automatic int us_to_cycles(input int clk_khz, input int us);
      return (clk_khz * us) / 1000;
   endfunction

   // byte lane merge under a lane enable
   function automatic logic [7:0] lane_pick(input logic en, input logic [7:0] fresh,
                                            input logic [7:0] stale);
      return en ? fresh : stale;
   endfunction

endpackage

// File: rtl/eeprom_pw_timer.sv
module eeprom_pw_timer
   import eeprom_pw_pkg::*;
#(
   parameter int LOAD_WIN_CYC = 300,
   parameter int COMMIT_CYC   = 1000,
   parameter int PROG_CYC     = 500,
   parameter int PAGE_WORDS   = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          run,
   input  logic                          acc,
   input  pw_state_e                     st,
   output logic                          win_open,
   output logic                          commit_due,
   output logic                          prog_wr,
   output logic [$clog2(PAGE_WORDS)-1:0] prog_idx,
   output logic                          prog_last
);
   localparam int CW  = $clog2(COMMIT_CYC + 1);
   localparam int PW  = $clog2(PROG_CYC + 1);
   localparam int PIW = $clog2(PAGE_WORDS);
   localparam logic [CW-1:0] WIN_L    = CW'(LOAD_WIN_CYC);
   localparam logic [CW-1:0] COMMIT_L = CW'(COMMIT_CYC);
   localparam logic [CW-1:0] DUE_L    = CW'(COMMIT_CYC - 1);
   localparam logic [PW-1:0] LAST_L   = PW'(PROG_CYC - 1);
   localparam logic [PW-1:0] WORDS_L  = PW'(PAGE_WORDS);

   logic [CW-1:0] since_q;
   logic [PW-1:0] prog_q;

   // cycles since the last accepted load, saturating at the commit limit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= '0;
      end else if (acc) begin
         since_q <= '0;
      end else if (st == PW_LOAD && since_q != COMMIT_L) begin
         since_q <= since_q + 1'b1;
      end
   end

   // programming progress, frozen while the inhibit input is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_q <= '0;
      end else if (commit_due) begin
         prog_q <= '0;
      end else if (st == PW_PROG && run && !prog_last) begin
         prog_q <= prog_q + 1'b1;
      end
   end

   assign win_open   = since_q < WIN_L;
   assign commit_due = (st == PW_LOAD) && (since_q == DUE_L);
   assign prog_last  = prog_q == LAST_L;
   assign prog_wr    = (st == PW_PROG) && run && (prog_q < WORDS_L);
   assign prog_idx   = prog_q[PIW-1:0];

endmodule

// File: rtl/eeprom_pw_page_buf.sv
module eeprom_pw_page_buf #(
   parameter int PAGE_BYTES = 128,
   parameter int LANES      = 4
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    clear,
   input  logic                                    load,
   input  logic [$clog2(PAGE_BYTES)-1:0]           load_off,
   input  logic [7:0]                              load_data,
   input  logic [$clog2(PAGE_BYTES/LANES)-1:0]     word_idx,
   output logic [8*LANES-1:0]                      word_data,
   output logic [LANES-1:0]                        word_be,
   output logic                                    last_b7
);
   localparam int LW = $clog2(LANES);

   logic [7:0]            bytes_q [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] vld_q;
   logic                  b7_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         b7_q  <= 1'b0;
      end else begin
         if (clear) vld_q <= '0;
         if (load) begin
            vld_q[load_off] <= 1'b1;
            b7_q            <= load_data[7];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (load) bytes_q[load_off] <= load_data;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign word_data[8*l +: 8] = bytes_q[{word_idx, LW'(l)}];
      assign word_be[l]          = vld_q[{word_idx, LW'(l)}];
   end

   assign last_b7 = b7_q;

endmodule

// File: rtl/eeprom_pw_array.sv
module eeprom_pw_array
   import eeprom_pw_pkg::*;
#(
   parameter int WORDS = 128,
   parameter int LANES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(WORDS)-1:0] waddr,
   input  logic [LANES-1:0]         wbe,
   input  logic [8*LANES-1:0]       wdata,
   input  logic                     re,
   input  logic [$clog2(WORDS)-1:0] raddr,
   output logic [8*LANES-1:0]       rword
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] cell_q [WORDS];
      logic [7:0] rd_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) cell_q[i] <= 8'h00;
            rd_q <= 8'h00;
         end else begin
            if (we) cell_q[waddr] <= lane_pick(wbe[l], wdata[8*l +: 8], cell_q[waddr]);
            if (re) rd_q <= cell_q[raddr];
         end
      end

      assign rword[8*l +: 8] = rd_q;
   end

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
   import eeprom_pw_pkg::*;
#(
   parameter int CLK_KHZ     = 10000,
   parameter int LOAD_WIN_US = 30,
   parameter int COMMIT_US   = 100,
   parameter int PROG_CYC    = 500,
   parameter int PAGE_BYTES  = 128,
   parameter int ARRAY_WORDS = 128
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               inhibit_n,
   input  logic                               wr_stb,
   input  logic [$clog2(ARRAY_WORDS*4)-1:0]   wr_addr,
   input  logic [7:0]                         wr_data,
   input  logic                               rd_en,
   input  logic [$clog2(ARRAY_WORDS)-1:0]     rd_addr,
   output logic [31:0]                        rdata,
   output logic                               rvalid,
   output logic                               rdy_oe,
   output logic                               rdy_o
);
   localparam int LANES        = 4;
   localparam int BA           = $clog2(ARRAY_WORDS * LANES);
   localparam int WA           = $clog2(ARRAY_WORDS);
   localparam int OW           = $clog2(PAGE_BYTES);
   localparam int PAGE_WORDS   = PAGE_BYTES / LANES;
   localparam int PIW          = $clog2(PAGE_WORDS);
   localparam int PGW          = BA - OW;
   localparam int LOAD_WIN_CYC = us_to_cycles(CLK_KHZ, LOAD_WIN_US);
   localparam int COMMIT_CYC   = us_to_cycles(CLK_KHZ, COMMIT_US);

   // elaboration-time parameter checks
   if (PAGE_BYTES != (1 << OW) || PAGE_BYTES < 2 * LANES || PAGE_BYTES > 128) begin : g_bad_page
      $error("page size must be a power of two between 8 and 128");
   end
   if (ARRAY_WORDS != (1 << WA) || ARRAY_WORDS * LANES <= PAGE_BYTES) begin : g_bad_array
      $error("array must be a power of two holding at least two pages");
   end
   if (LOAD_WIN_CYC < 1 || COMMIT_CYC <= LOAD_WIN_CYC) begin : g_bad_timing
      $error("commit interval must exceed a non-empty load window");
   end
   if (PROG_CYC < PAGE_WORDS) begin : g_bad_prog
      $error("programming time must cover one cycle per page word");
   end

   pw_state_e      st;
   logic           acc;
   logic           same_page;
   logic [PGW-1:0] page_q;
   logic           win_open, commit_due, prog_wr, prog_last;
   logic [PIW-1:0] prog_idx;
   logic [31:0]    buf_word, arr_word;
   logic [3:0]     buf_be;
   logic           last_b7;
   logic           rvalid_q, poll_q;

   assign same_page = wr_addr[BA-1:OW] == page_q;
   always_comb begin
      acc = 1'b0;
      if (wr_stb && inhibit_n) begin
         unique case (st)
            PW_IDLE: acc = 1'b1;
            PW_LOAD: acc = win_open && same_page;
            default: acc = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= PW_IDLE;
         page_q <= '0;
      end else begin
         unique case (st)
            PW_IDLE: if (acc) begin
               st     <= PW_LOAD;
               page_q <= wr_addr[BA-1:OW];
            end
            PW_LOAD: if (commit_due) st <= PW_PROG;
            PW_PROG: if (prog_last && inhibit_n) st <= PW_IDLE;
            default: st <= PW_IDLE;
         endcase
      end
   end

   eeprom_pw_timer #(
      .LOAD_WIN_CYC (LOAD_WIN_CYC),
      .COMMIT_CYC   (COMMIT_CYC),
      .PROG_CYC     (PROG_CYC),
      .PAGE_WORDS   (PAGE_WORDS)
   ) timer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (inhibit_n),
      .acc        (acc),
      .st         (st),
      .win_open   (win_open),
      .commit_due (commit_due),
      .prog_wr    (prog_wr),
      .prog_idx   (prog_idx),
      .prog_last  (prog_last)
   );

   eeprom_pw_page_buf #(
      .PAGE_BYTES (PAGE_BYTES),
      .LANES      (LANES)
   ) pbuf_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (acc && st == PW_IDLE),
      .load      (acc),
      .load_off  (wr_addr[OW-1:0]),
      .load_data (wr_data),
      .word_idx  (prog_idx),
      .word_data (buf_word),
      .word_be   (buf_be),
      .last_b7   (last_b7)
   );

   eeprom_pw_array #(
      .WORDS (ARRAY_WORDS),
      .LANES (LANES)
   ) array_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (prog_wr),
      .waddr ({page_q, prog_idx}),
      .wbe   (buf_be),
      .wdata (buf_word),
      .re    (rd_en && inhibit_n),
      .raddr (rd_addr),
      .rword (arr_word)
   );

   // read return: array data, polling status, or nothing when inhibited
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         poll_q   <= 1'b0;
      end else begin
         rvalid_q <= rd_en && inhibit_n;
         poll_q   <= st == PW_PROG;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_rlane
      assign rdata[8*l +: 8] = !rvalid_q ? 8'h00 :
                               poll_q    ? {~last_b7, 7'h00} :
                                           arr_word[8*l +: 8];
   end

   assign rvalid = rvalid_q;
   assign rdy_oe = st != PW_IDLE;
   assign rdy_o  = 1'b0;

endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk
   import eeprom_pw_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        inhibit_n,
   input logic        wr_stb,
   input logic        rd_en,
   input logic [31:0] rdata,
   input logic        rvalid,
   input logic        rdy_oe,
   input pw_state_e   st
);
   // R2: an accepted strobe from idle makes the busy pin drive next cycle
   a_r2_busy_on: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && inhibit_n && !rdy_oe) |=> rdy_oe)
      else $error("busy not raised after first load");

   // R5: the busy pin is released only out of programming
   a_r5_release_from_prog: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy_oe) |-> $past(st) == PW_PROG)
      else $error("busy released outside programming");

   // R7: polling word has equal lane top bits and nothing else
   a_r7_poll_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && inhibit_n && st == PW_PROG) |=>
      (rvalid && rdata[7] == rdata[15] && rdata[15] == rdata[23] &&
       rdata[23] == rdata[31] && (rdata & 32'h7F7F_7F7F) == 32'h0))
      else $error("malformed polling word");

   // R9: inhibited reads return nothing
   a_r9_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !inhibit_n) |=> (!rvalid && rdata == 32'h0))
      else $error("read passed while inhibited");

   // R9: inhibit keeps an idle controller idle
   a_r9_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!inhibit_n && !rdy_oe) |=> !rdy_oe)
      else $error("session opened while inhibited");

   // R9: programming cannot finish while inhibited
   a_r9_prog_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PW_PROG && !inhibit_n) |=> st == PW_PROG)
      else $error("programming advanced while inhibited");

   // R10: programming never falls back into a load session
   a_r10_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PW_PROG) |=> st != PW_LOAD)
      else $error("load session reopened during programming");

endmodule

bind eeprom_page_writer eeprom_page_writer_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .inhibit_n (inhibit_n),
   .wr_stb    (wr_stb),
   .rd_en     (rd_en),
   .rdata     (rdata),
   .rvalid    (rvalid),
   .rdy_oe    (rdy_oe),
   .st        (st)
);

// File: tb/eeprom_page_writer_tb_top.sv
`timescale 1ns/1ps
module eeprom_page_writer_tb_top;
   localparam int W = 300;   // load window, cycles
   localparam int C = 1000;  // commit interval, cycles
   localparam int P = 500;   // programming time, cycles

   logic        clk = 1'b0;
   logic        rst_n, inhibit_n, wr_stb, rd_en;
   logic [8:0]  wr_addr;
   logic [7:0]  wr_data;
   logic [6:0]  rd_addr;
   logic [31:0] rdata;
   logic        rvalid, rdy_oe, rdy_o;

   always #2.5 clk = ~clk;

   eeprom_page_writer dut_i (
      .clk(clk), .rst_n(rst_n), .inhibit_n(inhibit_n), .wr_stb(wr_stb),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
      .rdata(rdata), .rvalid(rvalid), .rdy_oe(rdy_oe), .rdy_o(rdy_o)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   logic [7:0]  ref_m [512];
   bit          pend = 1'b0;
   bit          pend_v;
   logic [31:0] pend_d;
   string       pend_tag;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_word(input int w);
      return {ref_m[4*w+3], ref_m[4*w+2], ref_m[4*w+1], ref_m[4*w]};
   endfunction

   function automatic logic [31:0] poll_word(input logic [7:0] last);
      return {4{~last[7], 7'h00}};
   endfunction

   // one clock: check the read issued last cycle, then drive this cycle
   task automatic step(input bit stb, input logic [8:0] wa, input logic [7:0] wd,
                       input bit rd, input logic [6:0] ra, input bit inh,
                       input logic [31:0] exp_d, input bit exp_v, input string tag);
      @(negedge clk);
      if (pend) begin
         chk(rvalid === pend_v, {pend_tag, " rvalid"}, {31'h0, rvalid}, {31'h0, pend_v});
         chk(rdata === pend_d, {pend_tag, " rdata"}, rdata, pend_d);
      end
      wr_stb = stb; wr_addr = wa; wr_data = wd;
      rd_en = rd; rd_addr = ra; inhibit_n = inh;
      pend = rd; pend_d = exp_d; pend_v = exp_v; pend_tag = tag;
   endtask

   task automatic idle();
      step(0, '0, '0, 0, '0, 1, '0, 0, "");
   endtask

   task automatic session(input int pg, input int n, input bit late, input bit wrongpg,
                          input int hold, input bit dense);
      logic [7:0] pd [128];
      bit         pv [128];
      logic [7:0] last, d;
      int         off, g, oth, lim;
      bit         s, r, inh;
      logic [8:0] a;
      logic [6:0] ra;
      logic [31:0] ed;
      bit         ev;
      string      tg;
      for (int i = 0; i < 128; i++) pv[i] = 1'b0;
      oth = (pg + 1) % 4;
      last = 8'h00;
      for (int i = 0; i < n; i++) begin
         if (i > 0) begin
            g = dense ? 1 + int'($urandom % 3) :
                (($urandom % 4) == 0 ? W : 1 + int'($urandom % W));
            for (int k = 1; k < g; k++) begin
               if (k == 1 && g >= 3) begin
                  ra = 7'(pg * 32 + int'($urandom % 32));
                  step(0, '0, '0, 1, ra, 1, ref_word(int'(ra)), 1, "R8 old data in session");
               end else idle();
            end
         end
         off = dense ? i : int'($urandom % 128);
         d = 8'($urandom);
         step(1, 9'(pg * 128 + off), d, 0, '0, 1, '0, 0, "");
         pd[off] = d; pv[off] = 1'b1; last = d;
      end
      lim = C + P + hold + 1;
      for (int m = 1; m <= lim; m++) begin
         s = 0; a = '0; d = '0; r = 0; ra = '0; ed = '0; ev = 0; tg = "";
         inh = !(hold > 0 && m >= C + 10 && m <= C + 9 + hold);
         if (wrongpg && m == 5) begin          // R10 foreign page
            s = 1; a = 9'(oth * 128); d = ~ref_m[oth * 128];
         end
         if (late && m == W + 1) begin         // R4 one cycle past the window
            s = 1; a = 9'(pg * 128); d = ~(pv[0] ? pd[0] : ref_m[pg * 128]);
         end
         if (m == C + 3) begin                 // R10 strobe during programming
            s = 1; a = 9'(pg * 128 + 1); d = ~(pv[1] ? pd[1] : ref_m[pg * 128 + 1]);
         end
         if (m == C + 4) begin
            r = 1; ra = 7'(pg * 32); ed = poll_word(last); ev = 1; tg = "R7 polling word";
         end
         if (hold >= 2 && m == C + 11) begin
            r = 1; ra = 7'(pg * 32); ed = '0; ev = 0; tg = "R9 inhibited read";
         end
         step(s, a, d, r, ra, inh, ed, ev, tg);
         if (m == 2) chk(rdy_oe === 1'b1, "R2 busy driven", {31'h0, rdy_oe}, 32'h1);
         if (m == 2) chk(rdy_o === 1'b0, "R2 busy level low", {31'h0, rdy_o}, 32'h0);
         if (m == lim - 1) chk(rdy_oe === 1'b1, "R5 busy until end", {31'h0, rdy_oe}, 32'h1);
         if (m == lim) chk(rdy_oe === 1'b0, "R5 busy released", {31'h0, rdy_oe}, 32'h0);
      end
      for (int i = 0; i < 128; i++) if (pv[i]) ref_m[pg * 128 + i] = pd[i];
      for (int w = 0; w < 32; w++)
         step(0, '0, '0, 1, 7'(pg * 32 + w), 1, ref_word(pg * 32 + w), 1, "R6 page contents");
      step(0, '0, '0, 1, 7'(oth * 32), 1, ref_word(oth * 32), 1, "R10 other page untouched");
      idle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h1BAD_5EED));
      for (int i = 0; i < 512; i++) ref_m[i] = 8'h00;
      rst_n = 0; inhibit_n = 1; wr_stb = 0; wr_addr = '0; wr_data = '0;
      rd_en = 0; rd_addr = '0;
      repeat (5) @(posedge clk);
      @(negedge clk) rst_n = 1;
      // R1 reset state
      chk(rdy_oe === 1'b0, "R1 rdy_oe after reset", {31'h0, rdy_oe}, 32'h0);
      chk(rdy_o === 1'b0, "R1 rdy_o after reset", {31'h0, rdy_o}, 32'h0);
      step(0, '0, '0, 1, 7'd0, 1, 32'h0, 1, "R1 word 0 cleared");
      step(0, '0, '0, 1, 7'd127, 1, 32'h0, 1, "R1 last word cleared");
      // R9 strobe and read while inhibited
      step(1, 9'd0, 8'h5A, 0, '0, 0, '0, 0, "");
      idle();
      chk(rdy_oe === 1'b0, "R9 strobe ignored while inhibited", {31'h0, rdy_oe}, 32'h0);
      step(0, '0, '0, 1, 7'd0, 0, 32'h0, 0, "R9 read blocked");
      idle();
      // directed corners: single byte with late and foreign strobes (R3 R4 R10)
      session(0, 1, 1, 1, 0, 0);
      // full page back to back with an inhibit gap in programming (R3 R9)
      session(2, 128, 0, 0, 40, 1);
      // short bursts with window-edge gaps, late strobe and inhibit
      session(1, 6, 1, 1, 7, 0);
      for (int t = 0; t < 9; t++)
         session(int'($urandom % 4), 1 + int'($urandom % 16), 1'($urandom),
                 1'($urandom), (($urandom % 2) == 0) ? 0 : 2 + int'($urandom % 30), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule